// File: doc/BRIEF.md
# Zero-Address Stack Machine Core

This block is a small processor core in which arithmetic and logic instructions name no operands. Each operand is taken from the top of an on-chip data stack, and each result is written back to the top. The core works through fetch, decode and execute for every instruction, so one instruction takes three clock cycles. The only instructions that carry a field are PUSH, which holds an immediate constant, and the jump and call instructions, which hold a target address. Subroutine return addresses live on a second hardware stack that is separate from the data stack.

The program memory sits inside the core. It is loaded through a simple write port while reset is held. When reset is released, execution starts at address 0. Values removed by POP leave through a valid/ready output register. A stalled consumer stalls the core. If either stack runs past its bounds, the core raises a sticky error flag and halts. A HALT instruction also halts the core. Only reset leaves the halted state.

Top module: `stack_core`

## Requirements
- R1: While reset is held, `halted`, `zero_flag`, `err_overflow`, `err_underflow` and `out_valid` are all 0. After reset is released, the first instruction executed is the one at program address 0.
- R2: An instruction word holds a 4-bit opcode in bits 15:12 and a 12-bit field in bits 11:0. The opcodes are 0 HALT, 1 PUSH, 2 POP, 3 ADD, 4 SUB, 5 AND, 6 OR, 7 XOR, 8 NOT, 9 SHL, A SHR, B JMP, C JZ, D JNZ, E CALL and F RET. Every instruction passes through the fetch, decode and execute phases in that order.
- R3: PUSH zero-extends its 12-bit field to 16 bits and places it on the top of the data stack. POP removes the top entry and loads it into the output register, which then presents it with `out_valid` high.
- R4: ADD, SUB, AND, OR and XOR each pop two entries and push one result, so the depth drops by one. The entry second from the top is the left operand and the top entry is the right operand; for example, SUB computes second minus top, modulo 2^16.
- R5: NOT replaces the top entry with its bitwise inverse and leaves the depth unchanged. SHL and SHR are binary operations that perform a logical shift of the second entry by the low 4 bits of the top entry.
- R6: Every ALU instruction (opcodes 3 to A) sets `zero_flag` when its result is 0 and clears it otherwise. PUSH and POP leave `zero_flag` unchanged.
- R7: JMP always loads the program counter from the low bits of the field. JZ does so only when `zero_flag` is 1, and JNZ only when it is 0. None of the jumps changes the data stack.
- R8: CALL pushes the address of the next instruction onto an 8-entry return stack and jumps to the field. RET pops that address and continues there, so nested calls return in last-in, first-out order.
- R9: HALT stops execution, and `halted` stays 1 until reset. The output register still drains while the core is halted.
- R10: A PUSH onto a full 8-entry data stack, or a CALL onto a full return stack, sets the sticky flag `err_overflow` and halts the core.
- R11: An instruction that needs more entries than its stack holds sets the sticky flag `err_underflow` and halts the core. The cases are a binary op with fewer than two data entries, NOT or POP on an empty data stack, and RET on an empty return stack.
- R12: If the output register is still holding an unaccepted value, a POP waits in execute until that value is taken. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds steady. A value is consumed on each clock edge where both `out_valid` and `out_ready` are 1, and no value is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 6 | Program memory write address |
| prog_wdata | input | 16 | Instruction word to write |
| out_data | output | 16 | Value most recently removed by POP |
| out_valid | output | 1 | Output register holds an unaccepted value |
| out_ready | input | 1 | Consumer accepts `out_data` on this edge |
| halted | output | 1 | Core has stopped (HALT or a stack error) |
| zero_flag | output | 1 | Result of the last ALU instruction was zero |
| err_overflow | output | 1 | Sticky: a push went past the depth of either stack |
| err_underflow | output | 1 | Sticky: an instruction needed more entries than its stack held |

## Verification
Each instruction takes exactly three cycles. A POP therefore raises `out_valid` at the edge that ends its execute phase, which is three cycles after the edge that fetched it, plus one cycle for each edge on which the output register stayed full. Because a stall stretches this timing, the bench does not sample POP results at fixed cycles. Instead, a driver queues the expected values in program order, and a monitor compares each one on the edge where `out_valid` and `out_ready` are both high; that monitor drives `out_ready` itself, always high, in a pattern, or low for a long window. Halt and error flags are checked only after `halted` has been seen and the queue has drained, and a fixed sample taken 30 cycles into a stall checks that the first POP value is being held.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int FIELD_W = INSTR_W - OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT = 4'h0, OP_PUSH = 4'h1, OP_POP  = 4'h2, OP_ADD  = 4'h3,
    OP_SUB  = 4'h4, OP_AND  = 4'h5, OP_OR   = 4'h6, OP_XOR  = 4'h7,
    OP_NOT  = 4'h8, OP_SHL  = 4'h9, OP_SHR  = 4'hA, OP_JMP  = 4'hB,
    OP_JZ   = 4'hC, OP_JNZ  = 4'hD, OP_CALL = 4'hE, OP_RET  = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_HALT
  } phase_e;

  function automatic logic is_binary(opcode_e op);
    return (op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR});
  endfunction
endpackage

// File: rtl/stk_imem.sv
module stk_imem #(
  parameter int AW = 6,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/stk_lifo.sv
module stk_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   pop_cnt,
  input  logic                         push_en,
  input  logic [W-1:0]                 push_data,
  output logic [W-1:0]                 top,
  output logic [W-1:0]                 second,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  ent_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] wr_idx;

  assign wr_idx = cnt_q - CW'(pop_cnt);
  assign count  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q - CW'(pop_cnt) + CW'(push_en);
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push_en && wr_idx == CW'(gi)) ent_q[gi] <= push_data;
    end
  end

  always_comb begin
    top    = '0;
    second = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top    = ent_q[i];
      if (cnt_q == CW'(i + 2)) second = ent_q[i];
    end
  end

  // The controller must never ask for more than the structure can do.
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_cnt == 2'd0) |-> (cnt_q != CW'(DEPTH)));
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(pop_cnt) <= cnt_q));
  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(DEPTH)));
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e       op,
  input  logic [W-1:0]  lhs,
  input  logic [W-1:0]  rhs,
  output logic [W-1:0]  res
);
  localparam int SH_W = $clog2(W);
  logic [SH_W-1:0] shamt;
  assign shamt = rhs[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_AND:  res = lhs & rhs;
      OP_OR:   res = lhs | rhs;
      OP_XOR:  res = lhs ^ rhs;
      OP_NOT:  res = ~rhs;
      OP_SHL:  res = lhs << shamt;
      OP_SHR:  res = lhs >> shamt;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stk_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PROG_AW = 6,
  parameter int DS_DEPTH = 8,
  parameter int RS_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [PROG_AW-1:0] prog_addr,
  input  logic [15:0]        prog_wdata,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               halted,
  output logic               zero_flag,
  output logic               err_overflow,
  output logic               err_underflow
);
  localparam int DS_CW = $clog2(DS_DEPTH+1);
  localparam int RS_CW = $clog2(RS_DEPTH+1);

  phase_e ph_q, ph_n;
  logic [PROG_AW-1:0] pc_q, pc_n;
  logic [INSTR_W-1:0] ir_q, imem_rd;
  opcode_e            op_q;
  logic [FIELD_W-1:0] fld_q;
  logic zero_q, zero_n, ovf_q, udf_q, ovf_set, udf_set;
  logic [DATA_W-1:0] out_q;
  logic out_v_q, out_load;

  logic [1:0]         ds_pop;
  logic               ds_push;
  logic [DATA_W-1:0]  ds_wdata, ds_top, ds_second, alu_res;
  logic [DS_CW-1:0]   ds_count;
  logic [1:0]         rs_pop;
  logic               rs_push;
  logic [PROG_AW-1:0] rs_wdata, rs_top, rs_second, tgt;
  logic [RS_CW-1:0]   rs_count;
  logic               out_free;

  stk_imem #(.AW(PROG_AW), .W(INSTR_W)) imem_i (
    .clk(clk), .wr_en(prog_we), .wr_addr(prog_addr), .wr_data(prog_wdata),
    .rd_addr(pc_q), .rd_data(imem_rd)
  );

  stk_lifo #(.W(DATA_W), .DEPTH(DS_DEPTH)) dstack_i (
    .clk(clk), .rst_n(rst_n), .pop_cnt(ds_pop), .push_en(ds_push),
    .push_data(ds_wdata), .top(ds_top), .second(ds_second), .count(ds_count)
  );

  stk_lifo #(.W(PROG_AW), .DEPTH(RS_DEPTH)) rstack_i (
    .clk(clk), .rst_n(rst_n), .pop_cnt(rs_pop), .push_en(rs_push),
    .push_data(rs_wdata), .top(rs_top), .second(rs_second), .count(rs_count)
  );

  stk_alu #(.W(DATA_W)) alu_i (
    .op(op_q), .lhs(ds_second), .rhs(ds_top), .res(alu_res)
  );

  assign tgt      = fld_q[PROG_AW-1:0];
  assign rs_wdata = pc_q + PROG_AW'(1);
  assign out_free = !out_v_q || out_ready;

  // Sequencer: one phase per cycle, execute resolves stacks, flags and pc.
  always_comb begin
    ph_n = ph_q; pc_n = pc_q; zero_n = zero_q;
    ds_pop = 2'd0; ds_push = 1'b0; ds_wdata = alu_res;
    rs_pop = 2'd0; rs_push = 1'b0;
    ovf_set = 1'b0; udf_set = 1'b0; out_load = 1'b0;
    unique case (ph_q)
      PH_FETCH:  ph_n = PH_DECODE;
      PH_DECODE: ph_n = PH_EXEC;
      PH_EXEC: begin
        ph_n = PH_FETCH;
        pc_n = pc_q + PROG_AW'(1);
        if (is_binary(op_q)) begin
          if (ds_count < DS_CW'(2)) udf_set = 1'b1;
          else begin
            ds_pop = 2'd2; ds_push = 1'b1; zero_n = (alu_res == '0);
          end
        end else begin
          unique case (op_q)
            OP_HALT: begin ph_n = PH_HALT; pc_n = pc_q; end
            OP_PUSH: begin
              if (ds_count == DS_CW'(DS_DEPTH)) ovf_set = 1'b1;
              else begin
                ds_push = 1'b1; ds_wdata = DATA_W'(fld_q);
              end
            end
            OP_POP: begin
              if (ds_count == '0) udf_set = 1'b1;
              else if (!out_free) begin ph_n = PH_EXEC; pc_n = pc_q; end
              else begin ds_pop = 2'd1; out_load = 1'b1; end
            end
            OP_NOT: begin
              if (ds_count == '0) udf_set = 1'b1;
              else begin
                ds_pop = 2'd1; ds_push = 1'b1; zero_n = (alu_res == '0);
              end
            end
            OP_JMP: pc_n = tgt;
            OP_JZ:  if (zero_q)  pc_n = tgt;
            OP_JNZ: if (!zero_q) pc_n = tgt;
            OP_CALL: begin
              if (rs_count == RS_CW'(RS_DEPTH)) ovf_set = 1'b1;
              else begin rs_push = 1'b1; pc_n = tgt; end
            end
            OP_RET: begin
              if (rs_count == '0) udf_set = 1'b1;
              else begin rs_pop = 2'd1; pc_n = rs_top; end
            end
            default: ;
          endcase
        end
        if (ovf_set || udf_set) begin
          ph_n = PH_HALT; pc_n = pc_q;
        end
      end
      PH_HALT: ;
      default: ph_n = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_FETCH; pc_q <= '0; ir_q <= '0; op_q <= OP_HALT; fld_q <= '0;
      zero_q <= 1'b0; ovf_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      ph_q <= ph_n; pc_q <= pc_n; zero_q <= zero_n;
      if (ph_q == PH_FETCH)  ir_q <= imem_rd;
      if (ph_q == PH_DECODE) begin
        op_q  <= opcode_e'(ir_q[INSTR_W-1:FIELD_W]);
        fld_q <= ir_q[FIELD_W-1:0];
      end
      if (ovf_set) ovf_q <= 1'b1;
      if (udf_set) udf_q <= 1'b1;
    end
  end

  // Output register with valid/ready hand-off.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v_q <= 1'b0; out_q <= '0;
    end else if (out_load) begin
      out_v_q <= 1'b1; out_q <= ds_top;
    end else if (out_v_q && out_ready) begin
      out_v_q <= 1'b0;
    end
  end

  assign out_data      = out_q;
  assign out_valid     = out_v_q;
  assign halted        = (ph_q == PH_HALT);
  assign zero_flag     = zero_q;
  assign err_overflow  = ovf_q;
  assign err_underflow = udf_q;

  assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_FETCH) |=> (ph_q == PH_DECODE));
  assert_decode_to_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DECODE) |=> (ph_q == PH_EXEC));
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> (err_overflow && halted));
  assert_udf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> (err_underflow && halted));
  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_rstack_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_push && rs_count != '0) |=> (rs_second == $past(rs_top)));
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_EXEC) |=> $stable(zero_flag));
endmodule

// File: tb/stack_core_tb_top.sv
`timescale 1ns/1ps
module stack_core_tb_top;
  import stk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [5:0] prog_addr = '0;
  logic [15:0] prog_wdata = '0;
  logic [15:0] out_data;
  logic out_valid, out_ready, halted, zero_flag, err_overflow, err_underflow;

  int n_cmp = 0;
  int n_bad = 0;
  int bp_mode = 0;
  int rel_cyc = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  stack_core dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .halted(halted), .zero_flag(zero_flag),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: drives out_ready, then records the hand-off due on the next edge.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst_n) rel_cyc = 0; else rel_cyc++;
      case (bp_mode)
        1:       out_ready = (rel_cyc % 3) == 0;
        2:       out_ready = (rel_cyc > 40);
        default: out_ready = 1'b1;
      endcase
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected output", int'(out_data), 0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, int'(out_data), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  task automatic emit(input int a, input opcode_e op, input int f);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 6'(a); prog_wdata = {op, 12'(f)};
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic expect_out(input int v, input string tag);
    exp_q.push_back(16'(v));
    tag_q.push_back(tag);
  endtask

  task automatic new_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < 64; a++) emit(a, OP_HALT, 0);
  endtask

  task automatic run(input string name, input logic e_ovf, input logic e_udf, input int e_zero);
    int cyc = 0;
    @(negedge clk);
    rst_n = 1'b1;
    while (!halted && cyc < 3000) begin @(negedge clk); cyc++; end
    chk(halted, {name, " R9 halted"}, int'(halted), 1);
    cyc = 0;
    while (exp_q.size() != 0 && cyc < 400) begin @(negedge clk); cyc++; end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, {name, " R12 all outputs seen"}, exp_q.size(), 0);
    chk(err_overflow == e_ovf, {name, " R10 overflow flag"}, int'(err_overflow), int'(e_ovf));
    chk(err_underflow == e_udf, {name, " R11 underflow flag"}, int'(err_underflow), int'(e_udf));
    if (e_zero >= 0) chk(zero_flag == e_zero[0], {name, " R6 zero flag"}, int'(zero_flag), e_zero);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!halted && !zero_flag && !err_overflow && !err_underflow && !out_valid,
        "R1 reset outputs", {halted, zero_flag, err_overflow, err_underflow, out_valid}, 0);

    // R3 R4: push/pop and binary ops; operand order second-op-top
    new_prog();
    emit(0, OP_PUSH, 7);    emit(1, OP_PUSH, 5);    emit(2, OP_ADD, 0);  emit(3, OP_POP, 0);
    emit(4, OP_PUSH, 3);    emit(5, OP_PUSH, 9);    emit(6, OP_SUB, 0);  emit(7, OP_POP, 0);
    emit(8, OP_PUSH, 'hF0F); emit(9, OP_PUSH, 'h0FF); emit(10, OP_AND, 0); emit(11, OP_POP, 0);
    emit(12, OP_PUSH, 'hF0F); emit(13, OP_PUSH, 'h0FF); emit(14, OP_OR, 0); emit(15, OP_POP, 0);
    emit(16, OP_PUSH, 'hF0F); emit(17, OP_PUSH, 'h0FF); emit(18, OP_XOR, 0); emit(19, OP_POP, 0);
    expect_out(12, "R4 ADD"); expect_out('hFFFA, "R4 SUB order");
    expect_out('h00F, "R4 AND"); expect_out('hFFF, "R4 OR"); expect_out('hFF0, "R4 XOR");
    run("p_alu", 1'b0, 1'b0, 0);

    // R6: zero result sets flag, PUSH and POP leave it alone
    new_prog();
    emit(0, OP_PUSH, 5); emit(1, OP_PUSH, 5); emit(2, OP_SUB, 0);
    emit(3, OP_PUSH, 1); emit(4, OP_POP, 0);
    expect_out(1, "R3 PUSH then POP");
    run("p_zero", 1'b0, 1'b0, 1);

    // R5: NOT keeps depth, shifts use low 4 bits of top
    new_prog();
    emit(0, OP_PUSH, 'h0F0); emit(1, OP_NOT, 0); emit(2, OP_POP, 0);
    emit(3, OP_PUSH, 3); emit(4, OP_PUSH, 2); emit(5, OP_SHL, 0); emit(6, OP_POP, 0);
    emit(7, OP_PUSH, 'h800); emit(8, OP_PUSH, 'h013); emit(9, OP_SHR, 0); emit(10, OP_POP, 0);
    emit(11, OP_PUSH, 1); emit(12, OP_PUSH, 'hFFF); emit(13, OP_NOT, 0);
    emit(14, OP_POP, 0); emit(15, OP_POP, 0);
    expect_out('hFF0F, "R5 NOT"); expect_out(12, "R5 SHL");
    expect_out('h100, "R5 SHR low bits"); expect_out('hF000, "R5 NOT top");
    expect_out(1, "R5 NOT depth kept");
    run("p_unary", 1'b0, 1'b0, 0);

    // R7: conditional and unconditional jumps
    new_prog();
    emit(0, OP_PUSH, 16); emit(1, OP_PUSH, 16); emit(2, OP_SUB, 0); emit(3, OP_JZ, 6);
    emit(4, OP_PUSH, 'hBAD); emit(5, OP_POP, 0); emit(6, OP_POP, 0); emit(7, OP_JNZ, 11);
    emit(8, OP_PUSH, 2); emit(9, OP_POP, 0); emit(10, OP_JMP, 14);
    emit(11, OP_PUSH, 'hBAD); emit(12, OP_POP, 0);
    emit(14, OP_PUSH, 3); emit(15, OP_PUSH, 4); emit(16, OP_ADD, 0); emit(17, OP_JNZ, 20);
    emit(18, OP_PUSH, 'hBAD); emit(19, OP_POP, 0); emit(20, OP_POP, 0);
    expect_out(0, "R7 JZ taken, stack kept"); expect_out(2, "R7 JNZ not taken");
    expect_out(7, "R7 JMP and JNZ taken");
    run("p_jump", 1'b0, 1'b0, 0);

    // R8: nested calls, with a patterned ready (R12)
    bp_mode = 1;
    new_prog();
    emit(0, OP_PUSH, 1); emit(1, OP_POP, 0); emit(2, OP_CALL, 10);
    emit(3, OP_PUSH, 4); emit(4, OP_POP, 0);
    emit(10, OP_PUSH, 2); emit(11, OP_POP, 0); emit(12, OP_CALL, 20);
    emit(13, OP_PUSH, 5); emit(14, OP_POP, 0); emit(15, OP_RET, 0);
    emit(20, OP_PUSH, 3); emit(21, OP_POP, 0); emit(22, OP_RET, 0);
    expect_out(1, "R8 main"); expect_out(2, "R8 f");
    expect_out(3, "R8 g"); expect_out(5, "R8 back in f"); expect_out(4, "R8 back in main");
    run("p_call", 1'b0, 1'b0, -1);
    bp_mode = 0;

    // R12: long stall holds the first value
    bp_mode = 2;
    new_prog();
    emit(0, OP_PUSH, 'hA); emit(1, OP_POP, 0); emit(2, OP_PUSH, 'hB); emit(3, OP_POP, 0);
    emit(4, OP_PUSH, 'hC); emit(5, OP_POP, 0);
    expect_out('hA, "R12 first"); expect_out('hB, "R12 second"); expect_out('hC, "R12 third");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(out_valid && out_data == 16'hA && !halted, "R12 held while stalled", int'(out_data), 'hA);
    run("p_stall", 1'b0, 1'b0, -1);
    bp_mode = 0;

    // R10: ninth push overflows
    new_prog();
    for (int i = 0; i < 9; i++) emit(i, OP_PUSH, i + 1);
    emit(9, OP_POP, 0);
    run("p_dovf", 1'b1, 1'b0, 0);

    // R11: POP on empty stack
    new_prog();
    emit(0, OP_PUSH, 1); emit(1, OP_POP, 0); emit(2, OP_POP, 0); emit(3, OP_PUSH, 9); emit(4, OP_POP, 0);
    expect_out(1, "R11 before underflow");
    run("p_dudf", 1'b0, 1'b1, 0);

    // R11: binary op with one entry
    new_prog();
    emit(0, OP_PUSH, 1); emit(1, OP_ADD, 0); emit(2, OP_POP, 0);
    run("p_binudf", 1'b0, 1'b1, 0);

    // R11: RET with empty return stack
    new_prog();
    emit(0, OP_RET, 0); emit(1, OP_PUSH, 1); emit(2, OP_POP, 0);
    run("p_rudf", 1'b0, 1'b1, 0);

    // R10: unbounded recursion overflows the return stack
    new_prog();
    emit(0, OP_CALL, 0);
    run("p_rovf", 1'b1, 1'b0, 0);

    // R9: halted stays halted
    new_prog();
    emit(0, OP_PUSH, 6); emit(1, OP_POP, 0); emit(2, OP_HALT, 0); emit(3, OP_PUSH, 7); emit(4, OP_POP, 0);
    expect_out(6, "R9 before HALT");
    run("p_halt", 1'b0, 1'b0, 0);
    repeat (60) @(negedge clk);
    chk(halted && !out_valid, "R9 still halted, nothing more out", int'(halted), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule